// File: doc/BRIEF.md
# Filtered Quadrature Decoder with Index Qualification

This block is the input stage of an encoder position counter. It receives the raw A and B channels and an active-low index line from an incremental encoder and turns them into one-cycle up and down count strobes plus a one-cycle index strobe. The counter, the bus access and any interrupt logic sit downstream and consume these strobes.

In the three quadrature resolutions, every input is first synchronised and then passed through a digital glitch filter. The filter samples on a filter clock, which is either every system clock cycle or every second cycle. A level is taken as valid only after it has been seen unchanged for a set number of consecutive filter samples. The validated A/B pair is decoded at one, two or four counts per quadrature cycle. A step in which both channels change together is never counted and raises a sticky error flag.

In clock/direction mode, the filter is bypassed: A is a count clock and B gives the direction. The index can be qualified against the A/B phase, in which case it is accepted only while A and B are equal. It can also be taken on its own edge. Clock/direction mode always uses the edge behaviour.

Top module: `quad_front`

## Requirements
- R1: `res_sel`=2'b11 (x4) produces one strobe for each validated single-channel change. A count is up when the A/B pair follows the order 00, 10, 11, 01 (A written first) and down for the reverse order.
- R2: `res_sel`=2'b10 (x2) produces one strobe for each validated change of A, on both of its edges. Changes of B alone give none.
- R3: `res_sel`=2'b01 (x1) produces a strobe only for a change of A while B is low. A rising gives up and A falling gives down, so a full cycle yields exactly one count.
- R4: `res_sel`=2'b00 (clock/direction) produces a strobe on each rising edge of the synchronised A. It is up when B is high and down when B is low. A and the index skip the glitch filter, so a one-cycle pulse is enough.
- R5: In the quadrature resolutions, A, B and the index take a new level only after it has been sampled on STABLE_N (default 3) consecutive filter-clock ticks. With one tick per cycle, a 2-cycle pulse is discarded and a 3-cycle pulse is accepted.
- R6: `fdiv2`=0 gives a filter tick every clock cycle. `fdiv2`=1 gives a tick every second cycle, so a 4-cycle pulse is accepted with `fdiv2`=0 and discarded with `fdiv2`=1.
- R7: With default parameters, x4 resolution and `fdiv2`=0, a change on A driven between clock edges shows as a strobe during the cycle after the 6th rising edge that follows it: 2 synchroniser stages, 3 filter ticks and 1 output register.
- R8: In the quadrature resolutions, a validated step in which A and B change together gives no strobe and sets `seq_err`. `seq_err` stays set through later legal steps until reset.
- R9: With `idx_sync_en`=0, each validated falling edge of the index gives exactly one `idx_strobe`, whatever the A/B state.
- R10: With `idx_sync_en`=1 in a quadrature resolution, `idx_strobe` pulses once when the index is low while validated A equals validated B. This also happens when the A/B phase enters equality while the index is already low, in the same cycle as the count strobe for that step.
- R11: In clock/direction mode, `idx_sync_en` has no effect and an unfiltered index falling edge gives a strobe even while A differs from B.
- R12: While `rst` is high and in the first cycle after it, all outputs are low. `step_up` and `step_dn` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| res_sel | input | 2 | Resolution: 00 clock/direction, 01 x1, 10 x2, 11 x4 |
| fdiv2 | input | 1 | 1: filter clock is the system clock divided by two |
| idx_sync_en | input | 1 | 1: qualify the index against the A/B phase (quadrature only) |
| enc_a | input | 1 | Raw encoder channel A (count clock in clock/direction mode) |
| enc_b | input | 1 | Raw encoder channel B (direction in clock/direction mode) |
| enc_idx_n | input | 1 | Raw active-low index |
| step_up | output | 1 | One-cycle up count strobe |
| step_dn | output | 1 | One-cycle down count strobe |
| idx_strobe | output | 1 | One-cycle accepted index strobe |
| seq_err | output | 1 | Sticky flag for a step in which A and B changed together |

## Verification
A count strobe and an index strobe can land in the same cycle, because both are registered from the same validated A/B pair. The bench provokes this in synchronous index mode. It holds the index low while A/B sits at 10, which must give no index strobe. It then steps to 11 and scans cycle by cycle for the first `step_up`, requiring `idx_strobe` to be high in exactly that sampled cycle. A separate case drives the index with A and B unequal in clock/direction mode, to show that qualification is dropped there.

// File: rtl/quad_front_pkg.sv
`timescale 1ns/1ps
package quad_front_pkg;

    typedef enum logic [1:0] {
        RES_CLKDIR = 2'b00,
        RES_X1     = 2'b01,
        RES_X2     = 2'b10,
        RES_X4     = 2'b11
    } res_e;

    typedef struct packed {
        logic a;
        logic b;
    } ab_t;

    typedef struct packed {
        logic up;
        logic dn;
    } step_t;

    localparam int CH_A   = 0;
    localparam int CH_B   = 1;
    localparam int CH_IDX = 2;
    localparam int N_CH   = 3;

    // Decode one validated quadrature step. Forward order is 00,10,11,01.
    function automatic step_t quad_step(ab_t prv, ab_t cur, res_e res);
        step_t s;
        logic  a_chg;
        logic  b_chg;
        logic  fwd_a;
        logic  fwd_b;
        s     = '0;
        a_chg = prv.a ^ cur.a;
        b_chg = prv.b ^ cur.b;
        fwd_a = cur.a ^ cur.b;
        fwd_b = ~(cur.a ^ cur.b);
        if (a_chg && !b_chg) begin
            unique case (res)
                RES_X4, RES_X2: begin
                    s.up = fwd_a;
                    s.dn = ~fwd_a;
                end
                RES_X1: begin
                    if (!cur.b) begin
                        s.up = cur.a;
                        s.dn = ~cur.a;
                    end
                end
                default: s = '0;
            endcase
        end else if (b_chg && !a_chg && res == RES_X4) begin
            s.up = fwd_b;
            s.dn = ~fwd_b;
        end
        return s;
    endfunction

endpackage

// File: rtl/qf_tick_gen.sv
`timescale 1ns/1ps
module qf_tick_gen (
    input  logic clk,
    input  logic rst,
    input  logic div2,
    output logic tick
);
    logic phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= 1'b0;
        else     phase_q <= ~phase_q;
    end

    assign tick = ~div2 | phase_q;

    // R6: undivided filter clock ticks every cycle
    p_tick_full_r6: assert property (@(posedge clk) disable iff (rst)
        !div2 |-> tick);

    // R6: divided filter clock never ticks on two adjacent cycles
    p_tick_half_r6: assert property (@(posedge clk) disable iff (rst)
        (div2 && tick) |=> (!tick || !div2));
endmodule

// File: rtl/qf_sync_filter.sv
`timescale 1ns/1ps
module qf_sync_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int STABLE_N    = 3,
    parameter bit RST_VAL     = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic raw_i,
    output logic sync_o,
    output logic filt_o
);
    localparam int RUN_W = $clog2(STABLE_N + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(STABLE_N - 1);

    logic [SYNC_STAGES-1:0] sh_q;
    logic [RUN_W-1:0]       run_q;
    logic                   filt_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= {SYNC_STAGES{RST_VAL}};
        else     sh_q <= {sh_q[SYNC_STAGES-2:0], raw_i};
    end

    assign sync_o = sh_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            filt_q <= RST_VAL;
            run_q  <= '0;
        end else if (tick) begin
            if (sync_o == filt_q) begin
                run_q <= '0;
            end else if (run_q == RUN_LAST) begin
                filt_q <= sync_o;
                run_q  <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign filt_o = filt_q;

    // R6: the validated level only moves on a filter tick
    p_filt_tick_r6: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(filt_o));

    // R5: a new validated level is the level the synchroniser presented
    p_filt_follow_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(filt_o) |-> (filt_o == $past(sync_o)));
endmodule

// File: rtl/qf_decode.sv
`timescale 1ns/1ps
module qf_decode
    import quad_front_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  res_e res,
    input  ab_t  ab_filt,
    input  ab_t  ab_sync,
    output logic cnt_up,
    output logic cnt_dn,
    output logic err
);
    logic  quad;
    ab_t   ab_in;
    ab_t   ab_prev;
    step_t qs;
    logic  both_chg;
    logic  a_rise;
    logic  up_nx;
    logic  dn_nx;

    always_comb begin
        quad     = (res != RES_CLKDIR);
        ab_in    = quad ? ab_filt : ab_sync;
        both_chg = (ab_in.a ^ ab_prev.a) & (ab_in.b ^ ab_prev.b);
        qs       = quad_step(ab_prev, ab_in, res);
        a_rise   = ab_in.a & ~ab_prev.a;
        if (quad) begin
            up_nx = qs.up;
            dn_nx = qs.dn;
        end else begin
            up_nx = a_rise & ab_in.b;
            dn_nx = a_rise & ~ab_in.b;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ab_prev <= '0;
            cnt_up  <= 1'b0;
            cnt_dn  <= 1'b0;
            err     <= 1'b0;
        end else begin
            ab_prev <= ab_in;
            cnt_up  <= up_nx;
            cnt_dn  <= dn_nx;
            if (quad && both_chg) err <= 1'b1;
        end
    end

    // R12: the two count strobes never coincide
    p_updn_excl_r12: assert property (@(posedge clk) disable iff (rst)
        !(cnt_up && cnt_dn));

    // R8: a double change gives no count and raises the error
    p_illegal_nocount_r8: assert property (@(posedge clk) disable iff (rst)
        (quad && both_chg) |=> (!cnt_up && !cnt_dn && err));

    // R8: the error flag holds until reset
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R4: clock/direction mode never raises the error
    p_nq_noerr_r4: assert property (@(posedge clk) disable iff (rst)
        !quad |=> $stable(err));
endmodule

// File: rtl/qf_index.sv
`timescale 1ns/1ps
module qf_index
    import quad_front_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic quad,
    input  logic sync_en,
    input  logic idx_filt_n,
    input  logic idx_sync_n,
    input  ab_t  ab_filt,
    output logic idx_pulse
);
    logic idx_src_n;
    logic sync_mode;
    logic phase_ok;
    logic armed;
    logic armed_q;

    always_comb begin
        idx_src_n = quad ? idx_filt_n : idx_sync_n;
        sync_mode = quad & sync_en;
        phase_ok  = ~(ab_filt.a ^ ab_filt.b);
        armed     = ~idx_src_n & (~sync_mode | phase_ok);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q   <= 1'b0;
            idx_pulse <= 1'b0;
        end else begin
            armed_q   <= armed;
            idx_pulse <= armed & ~armed_q;
        end
    end

    // R9: an accepted index is a single-cycle strobe
    p_idx_single_r9: assert property (@(posedge clk) disable iff (rst)
        idx_pulse |=> !idx_pulse);

    // R10: in synchronous mode a strobe follows an equal A/B phase
    p_idx_phase_r10: assert property (@(posedge clk) disable iff (rst)
        (idx_pulse && $past(sync_mode)) |-> $past(ab_filt.a == ab_filt.b));
endmodule

// File: rtl/quad_front.sv
`timescale 1ns/1ps
module quad_front
    import quad_front_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int STABLE_N    = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] res_sel,
    input  logic       fdiv2,
    input  logic       idx_sync_en,
    input  logic       enc_a,
    input  logic       enc_b,
    input  logic       enc_idx_n,
    output logic       step_up,
    output logic       step_dn,
    output logic       idx_strobe,
    output logic       seq_err
);
    // index idles high, A and B idle low
    localparam logic [N_CH-1:0] RST_VEC = 3'b100;

    res_e            res;
    logic            tick;
    logic [N_CH-1:0] raw_v;
    logic [N_CH-1:0] sync_v;
    logic [N_CH-1:0] filt_v;
    ab_t             ab_f;
    ab_t             ab_s;

    assign res   = res_e'(res_sel);
    assign raw_v = {enc_idx_n, enc_b, enc_a};

    qf_tick_gen u_tick (
        .clk  (clk),
        .rst  (rst),
        .div2 (fdiv2),
        .tick (tick)
    );

    for (genvar gi = 0; gi < N_CH; gi++) begin : g_ch
        qf_sync_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .STABLE_N    (STABLE_N),
            .RST_VAL     (RST_VEC[gi])
        ) u_ch (
            .clk    (clk),
            .rst    (rst),
            .tick   (tick),
            .raw_i  (raw_v[gi]),
            .sync_o (sync_v[gi]),
            .filt_o (filt_v[gi])
        );
    end

    assign ab_f = '{a: filt_v[CH_A], b: filt_v[CH_B]};
    assign ab_s = '{a: sync_v[CH_A], b: sync_v[CH_B]};

    qf_decode u_dec (
        .clk     (clk),
        .rst     (rst),
        .res     (res),
        .ab_filt (ab_f),
        .ab_sync (ab_s),
        .cnt_up  (step_up),
        .cnt_dn  (step_dn),
        .err     (seq_err)
    );

    qf_index u_idx (
        .clk        (clk),
        .rst        (rst),
        .quad       (res != RES_CLKDIR),
        .sync_en    (idx_sync_en),
        .idx_filt_n (filt_v[CH_IDX]),
        .idx_sync_n (sync_v[CH_IDX]),
        .ab_filt    (ab_f),
        .idx_pulse  (idx_strobe)
    );

    // R12: outputs are quiet in the first cycle after reset
    p_quiet_after_rst_r12: assert property (@(posedge clk)
        $fell(rst) |-> (!step_up && !step_dn && !idx_strobe && !seq_err));
endmodule

// File: tb/quad_front_bench.sv
`timescale 1ns/1ps
module quad_front_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] res_sel = 2'b11;
    logic       fdiv2 = 1'b0;
    logic       idx_sync_en = 1'b0;
    logic       enc_a = 1'b0;
    logic       enc_b = 1'b0;
    logic       enc_idx_n = 1'b1;
    logic       step_up;
    logic       step_dn;
    logic       idx_strobe;
    logic       seq_err;

    always #10 clk = ~clk;

    quad_front u_quad_front (
        .clk         (clk),
        .rst         (rst),
        .res_sel     (res_sel),
        .fdiv2       (fdiv2),
        .idx_sync_en (idx_sync_en),
        .enc_a       (enc_a),
        .enc_b       (enc_b),
        .enc_idx_n   (enc_idx_n),
        .step_up     (step_up),
        .step_dn     (step_dn),
        .idx_strobe  (idx_strobe),
        .seq_err     (seq_err)
    );

    int n_chk = 0;
    int n_fail = 0;
    int up_acc = 0;
    int dn_acc = 0;
    int idx_acc = 0;
    int both_acc = 0;
    int ph = 0;
    bit finished = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            up_acc   += int'(step_up);
            dn_acc   += int'(step_dn);
            idx_acc  += int'(idx_strobe);
            both_acc += int'(step_up & step_dn);
        end
    end

    // {res[1:0], div2, dir_up, steps[3:0], exp_up[3:0], exp_dn[3:0]}
    localparam int N_VEC = 9;
    localparam logic [15:0] VEC [0:N_VEC-1] = '{
        {2'b11, 1'b0, 1'b1, 4'd8, 4'd8, 4'd0},
        {2'b11, 1'b0, 1'b0, 4'd8, 4'd0, 4'd8},
        {2'b10, 1'b0, 1'b1, 4'd8, 4'd4, 4'd0},
        {2'b10, 1'b0, 1'b0, 4'd8, 4'd0, 4'd4},
        {2'b01, 1'b0, 1'b1, 4'd8, 4'd2, 4'd0},
        {2'b01, 1'b0, 1'b0, 4'd8, 4'd0, 4'd2},
        {2'b11, 1'b1, 1'b1, 4'd8, 4'd8, 4'd0},
        {2'b00, 1'b0, 1'b1, 4'd5, 4'd5, 4'd0},
        {2'b00, 1'b0, 1'b0, 4'd3, 4'd0, 4'd3}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic apply_ph();
        case (ph)
            0: begin enc_a = 1'b0; enc_b = 1'b0; end
            1: begin enc_a = 1'b1; enc_b = 1'b0; end
            2: begin enc_a = 1'b1; enc_b = 1'b1; end
            default: begin enc_a = 1'b0; enc_b = 1'b1; end
        endcase
    endtask

    task automatic qstep(input bit dir_up, input int hold);
        ph = dir_up ? (ph + 1) % 4 : (ph + 3) % 4;
        apply_ph();
        wait_cyc(hold);
    endtask

    task automatic nq_pulse(input bit dir_up);
        enc_b = dir_up;
        wait_cyc(2);
        enc_a = 1'b1;
        wait_cyc(4);
        enc_a = 1'b0;
        wait_cyc(4);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        enc_a = 1'b0;
        enc_b = 1'b0;
        enc_idx_n = 1'b1;
        ph = 0;
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(2);
    endtask

    initial begin
        #4_000_000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int bu;
        int bd;
        int bi;
        // R12: reset state
        wait_cyc(3);
        check("R12 reset up", int'(step_up), 0);
        check("R12 reset dn", int'(step_dn), 0);
        check("R12 reset idx", int'(idx_strobe), 0);
        check("R12 reset err", int'(seq_err), 0);
        rst = 1'b0;
        wait_cyc(1);
        check("R12 first cycle quiet", int'(step_up | step_dn | idx_strobe | seq_err), 0);
        wait_cyc(5);

        // table-driven resolution sweep
        for (int v = 0; v < N_VEC; v++) begin
            logic [15:0] e;
            string tag;
            int hold;
            e = VEC[v];
            res_sel = e[15:14];
            fdiv2 = e[13];
            hold = e[13] ? 16 : 8;
            case (e[15:14])
                2'b11: tag = e[13] ? "R6" : "R1";
                2'b10: tag = "R2";
                2'b01: tag = "R3";
                default: tag = "R4";
            endcase
            wait_cyc(20);
            bu = up_acc;
            bd = dn_acc;
            for (int s = 0; s < int'(e[11:8]); s++) begin
                if (e[15:14] == 2'b00) nq_pulse(e[12]);
                else qstep(e[12], hold);
            end
            wait_cyc(30);
            check({tag, " up count"}, up_acc - bu, int'(e[7:4]));
            check({tag, " down count"}, dn_acc - bd, int'(e[3:0]));
            enc_a = 1'b0;
            enc_b = 1'b0;
            ph = 0;
        end
        wait_cyc(10);

        // R4: one-cycle A pulse counts without filtering
        bu = up_acc;
        enc_b = 1'b1;
        wait_cyc(3);
        enc_a = 1'b1;
        wait_cyc(1);
        enc_a = 1'b0;
        wait_cyc(10);
        check("R4 one-cycle clock pulse", up_acc - bu, 1);
        enc_b = 1'b0;

        // R7: exact latency in x4, undivided
        res_sel = 2'b11;
        fdiv2 = 1'b0;
        do_reset();
        wait_cyc(5);
        enc_a = 1'b1;
        ph = 1;
        for (int k = 1; k <= 7; k++) begin
            @(negedge clk);
            if (k == 5) check("R7 not yet at edge 5", int'(step_up), 0);
            if (k == 6) check("R7 strobe at edge 6", int'(step_up), 1);
            if (k == 7) check("R7 strobe single cycle", int'(step_up), 0);
        end
        enc_a = 1'b0;
        ph = 0;
        wait_cyc(20);

        // R5: glitch width boundary at one tick per cycle
        bu = up_acc;
        bd = dn_acc;
        enc_a = 1'b1;
        wait_cyc(2);
        enc_a = 1'b0;
        wait_cyc(30);
        check("R5 2-cycle glitch rejected", (up_acc - bu) + (dn_acc - bd), 0);
        bu = up_acc;
        bd = dn_acc;
        enc_a = 1'b1;
        wait_cyc(3);
        enc_a = 1'b0;
        wait_cyc(30);
        check("R5 3-cycle pulse up", up_acc - bu, 1);
        check("R5 3-cycle pulse down", dn_acc - bd, 1);

        // R6: 4-cycle pulse against the divider setting
        fdiv2 = 1'b1;
        wait_cyc(10);
        bu = up_acc;
        enc_a = 1'b1;
        wait_cyc(4);
        enc_a = 1'b0;
        wait_cyc(40);
        check("R6 4-cycle pulse rejected at half rate", up_acc - bu, 0);
        fdiv2 = 1'b0;
        wait_cyc(10);
        bu = up_acc;
        enc_a = 1'b1;
        wait_cyc(4);
        enc_a = 1'b0;
        wait_cyc(40);
        check("R6 4-cycle pulse accepted at full rate", up_acc - bu, 1);

        // R8: both channels change together
        do_reset();
        bu = up_acc;
        bd = dn_acc;
        enc_a = 1'b1;
        enc_b = 1'b1;
        ph = 2;
        wait_cyc(20);
        check("R8 no count on double change", (up_acc - bu) + (dn_acc - bd), 0);
        check("R8 error raised", int'(seq_err), 1);
        bu = up_acc;
        qstep(1'b1, 20);
        check("R8 legal step still counts", up_acc - bu, 1);
        check("R8 error sticky", int'(seq_err), 1);
        do_reset();
        check("R8 error cleared by reset", int'(seq_err), 0);

        // R9: asynchronous index in quadrature mode, A/B at 10
        idx_sync_en = 1'b0;
        qstep(1'b1, 20);
        bi = idx_acc;
        enc_idx_n = 1'b0;
        wait_cyc(8);
        enc_idx_n = 1'b1;
        wait_cyc(20);
        check("R9 async index accepted", idx_acc - bi, 1);
        bi = idx_acc;
        enc_idx_n = 1'b0;
        wait_cyc(2);
        enc_idx_n = 1'b1;
        wait_cyc(20);
        check("R5 2-cycle index glitch rejected", idx_acc - bi, 0);

        // R10: synchronous index, phase 10 blocks, step to 11 releases
        idx_sync_en = 1'b1;
        wait_cyc(5);
        bi = idx_acc;
        enc_idx_n = 1'b0;
        wait_cyc(12);
        check("R10 blocked while A differs from B", idx_acc - bi, 0);
        begin
            int hit;
            int co;
            hit = -1;
            co = 0;
            ph = 2;
            apply_ph();
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (step_up && hit < 0) begin
                    hit = k;
                    co = int'(idx_strobe);
                end
            end
            check("R10 count strobe seen", int'(hit >= 0), 1);
            check("R10 index strobe in same cycle as count", co, 1);
        end
        check("R10 single index strobe on phase entry", idx_acc - bi, 1);
        enc_idx_n = 1'b1;
        wait_cyc(20);
        bi = idx_acc;
        enc_idx_n = 1'b0;
        wait_cyc(8);
        enc_idx_n = 1'b1;
        wait_cyc(20);
        check("R10 accepted at phase 11", idx_acc - bi, 1);

        // R11: clock/direction mode ignores qualification and filter
        res_sel = 2'b00;
        wait_cyc(5);
        enc_b = 1'b0;
        wait_cyc(10);
        bi = idx_acc;
        enc_idx_n = 1'b0;
        wait_cyc(1);
        enc_idx_n = 1'b1;
        wait_cyc(10);
        check("R11 unqualified one-cycle index", idx_acc - bi, 1);

        check("R12 up and down never together", both_acc, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule